// File: doc/BRIEF.md
# Model Broadcast and Record Dispatcher

This block sits between one inbound beat stream and a set of compute units. It has two phases, chosen by a plain phase input. In the load phase every inbound word is part of a scoring model, and it is copied to all units at once. A word moves only when every unit can take it, so all units hold the same model when loading ends. In the scoring phase the inbound stream carries fixed-size input records. Each record is 100 bytes long and is sent as 64-bit beats. A whole record goes to one unit, and the units take turns in a fixed rotation.

Both sides use a valid/ready handshake.

- **Inbound side.** A beat transfers on a cycle where `in_valid` and `in_ready` are both high. The sender must hold a beat stable until it transfers.
- **Unit side, load phase.** `in_ready` is the AND of every unit's ready. The units' valids rise together, and only in that case, so each unit must drive its ready without looking at its valid.
- **Unit side, scoring phase.** Only the current target unit can see a valid, and `in_ready` follows that unit's ready. If the target is busy, the block stalls. It never skips to another unit, so the unit that receives each record is fully determined by the record's position in the stream.

The phase is set by the surrounding control logic. Loading must finish before scoring begins. Returning to the load phase, or asserting reset, drops any record that is partly sent. After either event the next record is sent to unit 0.

Top module: `model_fanout_dispatch`

## Requirements
- R1: While `rst_n` is low, `in_ready` and every `cu_valid` bit are 0. After reset, the first record of the scoring phase goes to unit 0 (bit 0 of `cu_valid`).
- R2: In the load phase, `in_ready` equals the AND of all `cu_ready` bits. When `in_valid` is high and all units are ready, every `cu_valid` bit is 1 in the same cycle. Otherwise every `cu_valid` bit is 0. `cu_data` always equals `in_data`.
- R3: In the load phase, `cu_keep` is 8'hFF, `cu_last` is 0 and `cu_model` is 1.
- R4: In the scoring phase, at most one `cu_valid` bit is high, and only the current target's bit can be high. `in_ready` equals that target's `cu_ready` bit. `cu_model` is 0.
- R5: A record is 13 beats (100 bytes in 8-byte beats). `cu_last` is 1 exactly while the 13th beat of a record is presented. On that beat `cu_keep` is 8'h0F, where bit i marks byte i, meaning bits [31:0] are valid. On every other beat `cu_keep` is 8'hFF.
- R6: The target moves 0, 1, 2, 3, 0, ... and advances only on the clock edge where a record's 13th beat transfers. It never changes in the middle of a record.
- R7: When the target unit's ready is low, `in_ready` is 0 and no other unit gets a valid, whatever the other units' readies are.
- R8: Any cycle in the load phase resets the beat count and the target. A partly sent record is dropped, and the next scoring beat is beat 1 of a record sent to unit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| score_mode | input | 1 | 0 = load phase (broadcast), 1 = scoring phase (rotation) |
| in_valid | input | 1 | Inbound beat valid |
| in_ready | output | 1 | Inbound beat accepted when high with `in_valid` |
| in_data | input | 64 | Inbound beat |
| cu_valid | output | 4 | Per-unit valid |
| cu_ready | input | 4 | Per-unit ready |
| cu_data | output | 64 | Beat shared by all units |
| cu_keep | output | 8 | Byte-valid mask, bit i marks byte i |
| cu_last | output | 1 | Final beat of a record |
| cu_model | output | 1 | Beat belongs to the model, not a record |

## Verification
Two events can land on the same clock edge: the transfer of a record's final beat, which advances the target, and a change of phase or a stall at the next target. The bench creates these collisions by driving random valid and per-unit ready patterns over long runs. It also switches to the load phase part way through a record, and asserts reset part way through a record. A behavioural model tracks the beat count and target with plain integers. On every cycle the ready, the per-unit valids, the keep mask and the last flag are compared with that model. This shows whether a stall on a final beat holds the target back, and whether an abandoned record leaves a stale beat count behind.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
  typedef enum logic {
    PH_LOAD  = 1'b0,
    PH_SCORE = 1'b1
  } phase_e;

  function automatic int beats_for(input int bytes, input int beat_bytes);
    return (bytes + beat_bytes - 1) / beat_bytes;
  endfunction
endpackage

// File: rtl/dfd_beat_track.sv
module dfd_beat_track #(
  parameter int REC_BEATS = 13,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] beat_idx,
  output logic             at_tail
);
  localparam logic [CNT_W-1:0] TAIL_IDX = CNT_W'(REC_BEATS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (advance) begin
      cnt_q <= (cnt_q == TAIL_IDX) ? '0 : cnt_q + 1'b1;
    end
  end

  assign beat_idx = cnt_q;
  assign at_tail  = (cnt_q == TAIL_IDX);
endmodule

// File: rtl/dfd_rr_ptr.sv
module dfd_rr_ptr #(
  parameter int NUM_UNITS = 4,
  parameter int PTR_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST_UNIT = PTR_W'(NUM_UNITS - 1);

  logic [PTR_W-1:0] ptr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_r <= '0;
    end else if (clear) begin
      ptr_r <= '0;
    end else if (step) begin
      ptr_r <= (ptr_r == LAST_UNIT) ? '0 : ptr_r + 1'b1;
    end
  end

  assign ptr = ptr_r;
endmodule

// File: rtl/dfd_lane_steer.sv
module dfd_lane_steer #(
  parameter int NUM_UNITS  = 4,
  parameter int PTR_W      = 2,
  parameter int BEAT_BYTES = 8,
  parameter logic [BEAT_BYTES-1:0] TAIL_KEEP = '1
) (
  input  logic                  enable,
  input  logic                  score,
  input  logic                  in_valid,
  input  logic [NUM_UNITS-1:0]  unit_ready,
  input  logic [PTR_W-1:0]      target,
  input  logic                  at_tail,
  output logic                  up_ready,
  output logic [NUM_UNITS-1:0]  unit_valid,
  output logic [BEAT_BYTES-1:0] keep,
  output logic                  last
);
  logic all_ready;
  logic [NUM_UNITS-1:0] sel;

  assign all_ready = &unit_ready;

  for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_lane
    assign sel[gi]        = (target == PTR_W'(gi));
    assign unit_valid[gi] = enable & in_valid & (score ? sel[gi] : all_ready);
  end

  assign up_ready = enable & (score ? |(sel & unit_ready) : all_ready);
  assign last     = score & at_tail;
  assign keep     = last ? TAIL_KEEP : '1;
endmodule

// File: rtl/model_fanout_dispatch.sv
module model_fanout_dispatch #(
  parameter int NUM_UNITS  = 4,
  parameter int BEAT_BYTES = 8,
  parameter int REC_BYTES  = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    score_mode,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BEAT_BYTES*8-1:0] in_data,
  output logic [NUM_UNITS-1:0]    cu_valid,
  input  logic [NUM_UNITS-1:0]    cu_ready,
  output logic [BEAT_BYTES*8-1:0] cu_data,
  output logic [BEAT_BYTES-1:0]   cu_keep,
  output logic                    cu_last,
  output logic                    cu_model
);
  import dfd_pkg::*;

  localparam int REC_BEATS  = beats_for(REC_BYTES, BEAT_BYTES);
  localparam int TAIL_BYTES = REC_BYTES - (REC_BEATS - 1) * BEAT_BYTES;
  localparam int CNT_W      = (REC_BEATS > 1) ? $clog2(REC_BEATS) : 1;
  localparam int PTR_W      = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam logic [BEAT_BYTES-1:0] TAIL_KEEP = BEAT_BYTES'((64'd1 << TAIL_BYTES) - 64'd1);

  phase_e           phase;
  logic             is_score;
  logic             xfer;
  logic [CNT_W-1:0] beat_idx;
  logic             at_tail;
  logic [PTR_W-1:0] ptr_q;

  assign phase    = phase_e'(score_mode);
  assign is_score = (phase == PH_SCORE);
  assign xfer     = in_valid & in_ready;

  dfd_beat_track #(
    .REC_BEATS (REC_BEATS),
    .CNT_W     (CNT_W)
  ) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!is_score),
    .advance  (is_score & xfer),
    .beat_idx (beat_idx),
    .at_tail  (at_tail)
  );

  dfd_rr_ptr #(
    .NUM_UNITS (NUM_UNITS),
    .PTR_W     (PTR_W)
  ) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!is_score),
    .step  (is_score & xfer & at_tail),
    .ptr   (ptr_q)
  );

  dfd_lane_steer #(
    .NUM_UNITS  (NUM_UNITS),
    .PTR_W      (PTR_W),
    .BEAT_BYTES (BEAT_BYTES),
    .TAIL_KEEP  (TAIL_KEEP)
  ) u_steer (
    .enable     (rst_n),
    .score      (is_score),
    .in_valid   (in_valid),
    .unit_ready (cu_ready),
    .target     (ptr_q),
    .at_tail    (at_tail),
    .up_ready   (in_ready),
    .unit_valid (cu_valid),
    .keep       (cu_keep),
    .last       (cu_last)
  );

  assign cu_data  = in_data;
  assign cu_model = !is_score;

  logic unused_beat;
  assign unused_beat = ^beat_idx;
endmodule

// File: rtl/dfd_checker.sv
module dfd_checker #(
  parameter int NUM_UNITS  = 4,
  parameter int PTR_W      = 2,
  parameter int BEAT_BYTES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  score_mode,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [NUM_UNITS-1:0]  cu_valid,
  input logic [NUM_UNITS-1:0]  cu_ready,
  input logic [BEAT_BYTES-1:0] cu_keep,
  input logic                  cu_last,
  input logic [PTR_W-1:0]      ptr_q
);
  logic [PTR_W-1:0] ptr_next;
  assign ptr_next = (ptr_q == PTR_W'(NUM_UNITS - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!in_ready && cu_valid == '0);
    end
  end

  a_r2_broadcast_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!score_mode && in_valid && in_ready) |-> (&cu_valid));

  a_r2_no_partial_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (!score_mode && !(&cu_ready)) |-> (cu_valid == '0));

  a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    score_mode |-> $onehot0(cu_valid));

  a_r5_full_keep_midrecord: assert property (@(posedge clk) disable iff (!rst_n)
    !cu_last |-> (&cu_keep));

  a_r6_hold_midrecord: assert property (@(posedge clk) disable iff (!rst_n)
    (score_mode && in_valid && in_ready && !cu_last) |=> (!score_mode || $stable(ptr_q)));

  a_r6_step_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (score_mode && in_valid && in_ready && cu_last) |=> (!score_mode || ptr_q == $past(ptr_next)));

  a_r7_stall_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (score_mode && !cu_ready[ptr_q]) |-> (!in_ready && (cu_valid & ~(cu_valid & cu_ready)) == cu_valid));

  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !score_mode |=> (ptr_q == '0));
endmodule

bind model_fanout_dispatch dfd_checker #(
  .NUM_UNITS  (NUM_UNITS),
  .PTR_W      (PTR_W),
  .BEAT_BYTES (BEAT_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .score_mode (score_mode),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cu_valid   (cu_valid),
  .cu_ready   (cu_ready),
  .cu_keep    (cu_keep),
  .cu_last    (cu_last),
  .ptr_q      (ptr_q)
);

// File: tb/test_model_fanout_dispatch.sv
`timescale 1ns/1ps
module test_model_fanout_dispatch;
  localparam int N  = 4;
  localparam int RB = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        score_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [3:0]  cu_valid;
  logic [3:0]  cu_ready = '0;
  logic [63:0] cu_data;
  logic [7:0]  cu_keep;
  logic        cu_last;
  logic        cu_model;

  always #2 clk = ~clk;

  model_fanout_dispatch i_model_fanout_dispatch (
    .clk(clk), .rst_n(rst_n), .score_mode(score_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cu_valid(cu_valid), .cu_ready(cu_ready), .cu_data(cu_data),
    .cu_keep(cu_keep), .cu_last(cu_last), .cu_model(cu_model)
  );

  int n_run = 0;
  int n_fail = 0;
  int m_ptr = 0;
  int m_beat = 0;

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit rst, input bit v, input logic [63:0] d,
                      input logic [3:0] rdy, input bit sc, input string force_tag);
    bit load, allr;
    logic       e_ready, e_last;
    logic [3:0] e_valid;
    logic [7:0] e_keep;
    string tr, tv, tk;
    @(negedge clk);
    rst_n = !rst; in_valid = v; in_data = d; cu_ready = rdy; score_mode = sc;
    if (rst) begin m_ptr = 0; m_beat = 0; end
    #0.5;
    load = !sc;
    allr = &rdy;
    e_ready = rst ? 1'b0 : (load ? allr : rdy[m_ptr]);
    e_valid = (rst || !v) ? 4'h0 : (load ? (allr ? 4'hF : 4'h0) : (4'b0001 << m_ptr));
    e_last  = sc && (m_beat == RB - 1);
    e_keep  = e_last ? 8'h0F : 8'hFF;
    tr = rst ? "R1" : (load ? "R2" : ((v && !rdy[m_ptr]) ? "R7" : "R4"));
    tv = tr;
    if (!rst && sc && v && m_beat == 0 && m_ptr != 0) tv = "R6";
    tk = load ? "R3" : "R5";
    if (force_tag != "") begin tr = force_tag; tv = force_tag; end
    cmp(tr, "in_ready", 64'(in_ready), 64'(e_ready));
    cmp(tv, "cu_valid", 64'(cu_valid), 64'(e_valid));
    cmp(tk, "cu_keep", 64'(cu_keep), 64'(e_keep));
    cmp(tk, "cu_last", 64'(cu_last), 64'(e_last));
    cmp(load ? "R3" : "R4", "cu_model", 64'(cu_model), 64'(load));
    cmp("R2", "cu_data", cu_data, d);
    if (rst || load) begin
      m_ptr = 0; m_beat = 0;
    end else if (v && rdy[m_ptr]) begin
      if (m_beat == RB - 1) begin m_beat = 0; m_ptr = (m_ptr + 1) % N; end
      else m_beat++;
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 1, rnd64(), 4'hF, 1, "R1");
    // R2, R3: load phase broadcast with mixed readiness
    for (int i = 0; i < 60; i++)
      step(0, ($urandom % 4) != 0, rnd64(), ($urandom % 3 != 0) ? 4'hF : 4'($urandom), 0, "");
    // R1: first scoring beat after load goes to unit 0
    step(0, 1, rnd64(), 4'hF, 1, "R1");
    // R5, R6: full records with every unit ready
    for (int i = 0; i < 6 * RB; i++) step(0, 1, rnd64(), 4'hF, 1, "");
    // R4, R6, R7: random valid and readiness
    for (int i = 0; i < 2500; i++)
      step(0, ($urandom % 4) != 0, rnd64(), 4'($urandom), 1, "");
    // R8: abandon a record by returning to load
    for (int i = 0; i < 5; i++) step(0, 1, rnd64(), 4'hF, 1, "");
    step(0, 1, rnd64(), 4'hF, 0, "R8");
    step(0, 0, rnd64(), 4'hF, 0, "R8");
    step(0, 1, rnd64(), 4'h1, 1, "R8");
    for (int i = 0; i < RB + 3; i++) step(0, 1, rnd64(), 4'hF, 1, "");
    // R1: reset part way through a record
    for (int i = 0; i < 4; i++) step(0, 1, rnd64(), 4'hF, 1, "");
    step(1, 1, rnd64(), 4'hF, 1, "R1");
    step(1, 1, rnd64(), 4'hF, 1, "R1");
    step(0, 1, rnd64(), 4'h1, 1, "R1");
    // mixed phases and collisions
    for (int i = 0; i < 3000; i++)
      step(0, ($urandom % 5) != 0, rnd64(), 4'($urandom | (($urandom % 2) ? 4'hF : 4'h0)),
           ($urandom % 40) != 0, "");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule